// File: doc/BRIEF.md
# Fault Effect Classifier

This block watches two copies of a circuit under test that run side by side: a golden reference and a copy carrying an injected fault. The faulty copy also drives a concurrent error detection (CED) flag. On every cycle where the valid strobe is high, the block compares the two output words. It notes whether the faulty copy's result was wrong and whether the CED flag was raised on that vector.

A test window closes on a window-end strobe. At that point the block sorts the fault into one of four effect classes. A fault is hidden when it never corrupts a result. It is caught when every wrong result carries the flag. It is missed when no wrong result carries the flag. It is partial when the flag is sometimes raised on a wrong result and sometimes not. From the class the block derives three properties: fault-secure, self-testing and totally-self-checking.

Saturating counters keep a running tally of each class over many windows. A separate counter tallies false alarms, which are flags raised on correct results. A synchronous clear input empties all of these counters.

Top module: `fault_effect_classifier`

## Requirements
- R1: A vector is compared only in a cycle where `vld_i` is 1. It is wrong when `tested_i` differs from `golden_i` in any bit. When `vld_i` is 0, data and `ced_i` have no effect on the window or on any counter.
- R2: A window with no wrong vector is classed hidden, `res_class_o` = 0.
- R3: A window with at least one wrong vector, where every wrong vector had `ced_i` = 1, is classed caught, `res_class_o` = 1.
- R4: A window with at least one wrong vector, where no wrong vector had `ced_i` = 1, is classed missed, `res_class_o` = 2.
- R5: A window with wrong vectors both with and without `ced_i` = 1 is classed partial, `res_class_o` = 3.
- R6: With a result, `res_fs_o` is 1 exactly for class 0 or 1, `res_st_o` is 1 exactly for class 1 or 3, and `res_tsc_o` is 1 exactly for class 1.
- R7: `res_vld_o` is 1 only in the cycle right after a cycle with `win_end_i` = 1, and in that cycle it is always 1.
- R8: A vector presented in the same cycle as `win_end_i` belongs to the window that is closing. The next window starts with no history.
- R9: Each valid, correct vector with `ced_i` = 1 adds one to `fa_cnt_o`. Such a vector never changes the class.
- R10: At each window end, the counter for the assigned class (`cnt_hidden_o`, `cnt_caught_o`, `cnt_missed_o`, `cnt_partial_o`) rises by one. The new value is visible together with the result. All counters hold at their all-ones value instead of wrapping.
- R11: When `clear_i` is 1 in a cycle, all five counters read 0 in the next cycle. This takes priority over any increment in that same cycle. The result path is not affected.
- R12: After reset, `res_vld_o`, the result fields and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all counters |
| vld_i | input | 1 | Vector valid strobe |
| golden_i | input | DATA_W | Output word of the golden copy |
| tested_i | input | DATA_W | Output word of the faulty copy |
| ced_i | input | 1 | Error detection flag of the faulty copy |
| win_end_i | input | 1 | Last cycle of the current window |
| res_vld_o | output | 1 | Result valid, one cycle |
| res_class_o | output | 2 | Effect class: 0 hidden, 1 caught, 2 missed, 3 partial |
| res_fs_o | output | 1 | Fault-secure property |
| res_st_o | output | 1 | Self-testing property |
| res_tsc_o | output | 1 | Totally-self-checking property |
| cnt_hidden_o | output | CNT_W | Windows classed hidden |
| cnt_caught_o | output | CNT_W | Windows classed caught |
| cnt_missed_o | output | CNT_W | Windows classed missed |
| cnt_partial_o | output | CNT_W | Windows classed partial |
| fa_cnt_o | output | CNT_W | False alarms |

## Verification
Some rules are checked by assertions on every cycle:
- the result appears exactly one cycle after the window-end strobe;
- the accumulators are empty after a window closes, and invalid cycles leave them alone;
- the property bits agree with the class;
- at most one class counter moves per cycle, and a counter stops at its ceiling;
- a clear empties every counter.

Whether the class itself is right for a given sequence of vectors can only be shown by the bench. It sweeps every three-vector window built from five vector kinds and computes the expected class, counters and false alarms in its own model. That sweep also covers vectors on the strobe cycle, saturation, and a clear that lands on a window end.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [1:0] {
    FX_HIDDEN  = 2'd0,
    FX_CAUGHT  = 2'd1,
    FX_MISSED  = 2'd2,
    FX_PARTIAL = 2'd3
  } fx_class_e;

  localparam int unsigned FX_NUM = 4;

  // class from the three window summaries
  function automatic fx_class_e fx_classify(input logic wrong, input logic caught,
                                            input logic missed);
    if (!wrong)               return FX_HIDDEN;
    else if (caught && missed) return FX_PARTIAL;
    else if (caught)          return FX_CAUGHT;
    else                      return FX_MISSED;
  endfunction

  function automatic logic fx_secure(input fx_class_e c);
    return (c == FX_HIDDEN) || (c == FX_CAUGHT);
  endfunction

  function automatic logic fx_selftest(input fx_class_e c);
    return (c == FX_CAUGHT) || (c == FX_PARTIAL);
  endfunction

  function automatic logic fx_tsc(input fx_class_e c);
    return c == FX_CAUGHT;
  endfunction

endpackage

// File: rtl/fec_compare.sv
module fec_compare #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              vld_i,
  input  logic [DATA_W-1:0] golden_i,
  input  logic [DATA_W-1:0] tested_i,
  input  logic              ced_i,
  output logic              wrong_o,
  output logic              caught_o,
  output logic              missed_o,
  output logic              false_alarm_o
);
  logic differ;

  assign differ        = |(golden_i ^ tested_i);
  assign wrong_o       = vld_i && differ;
  assign caught_o      = wrong_o && ced_i;
  assign missed_o      = wrong_o && !ced_i;
  assign false_alarm_o = vld_i && !differ && ced_i;
endmodule

// File: rtl/fec_sticky.sv
module fec_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic win_end_i,
  input  logic ev_wrong_i,
  input  logic ev_caught_i,
  input  logic ev_missed_i,
  output logic wrong_q_o,
  output logic caught_q_o,
  output logic missed_q_o,
  output logic wrong_all_o,
  output logic caught_all_o,
  output logic missed_all_o
);
  // view that includes the current cycle's vector
  assign wrong_all_o  = wrong_q_o  | ev_wrong_i;
  assign caught_all_o = caught_q_o | ev_caught_i;
  assign missed_all_o = missed_q_o | ev_missed_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrong_q_o  <= 1'b0;
      caught_q_o <= 1'b0;
      missed_q_o <= 1'b0;
    end else if (win_end_i) begin
      wrong_q_o  <= 1'b0;
      caught_q_o <= 1'b0;
      missed_q_o <= 1'b0;
    end else begin
      wrong_q_o  <= wrong_all_o;
      caught_q_o <= caught_all_o;
      missed_q_o <= missed_all_o;
    end
  end
endmodule

// File: rtl/fec_sat_counter.sv
module fec_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != TOP)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fault_effect_classifier.sv
module fault_effect_classifier
  import fec_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] golden_i,
  input  logic [DATA_W-1:0] tested_i,
  input  logic              ced_i,
  input  logic              win_end_i,
  output logic              res_vld_o,
  output logic [1:0]        res_class_o,
  output logic              res_fs_o,
  output logic              res_st_o,
  output logic              res_tsc_o,
  output logic [CNT_W-1:0]  cnt_hidden_o,
  output logic [CNT_W-1:0]  cnt_caught_o,
  output logic [CNT_W-1:0]  cnt_missed_o,
  output logic [CNT_W-1:0]  cnt_partial_o,
  output logic [CNT_W-1:0]  fa_cnt_o
);
  // named internal events
  logic ev_wrong, ev_caught, ev_missed, ev_false_alarm;
  logic stk_wrong_q, stk_caught_q, stk_missed_q;
  logic win_wrong, win_caught, win_missed;
  fx_class_e cls_now;
  logic [FX_NUM-1:0] cls_inc;
  logic [CNT_W-1:0]  cls_cnt [FX_NUM];

  fec_compare #(.DATA_W(DATA_W)) u_cmp (
    .vld_i(vld_i), .golden_i(golden_i), .tested_i(tested_i), .ced_i(ced_i),
    .wrong_o(ev_wrong), .caught_o(ev_caught), .missed_o(ev_missed),
    .false_alarm_o(ev_false_alarm)
  );

  fec_sticky u_stk (
    .clk(clk), .rst_n(rst_n), .win_end_i(win_end_i),
    .ev_wrong_i(ev_wrong), .ev_caught_i(ev_caught), .ev_missed_i(ev_missed),
    .wrong_q_o(stk_wrong_q), .caught_q_o(stk_caught_q), .missed_q_o(stk_missed_q),
    .wrong_all_o(win_wrong), .caught_all_o(win_caught), .missed_all_o(win_missed)
  );

  assign cls_now = fx_classify(win_wrong, win_caught, win_missed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o   <= 1'b0;
      res_class_o <= 2'd0;
      res_fs_o    <= 1'b0;
      res_st_o    <= 1'b0;
      res_tsc_o   <= 1'b0;
    end else begin
      res_vld_o <= win_end_i;
      if (win_end_i) begin
        res_class_o <= cls_now;
        res_fs_o    <= fx_secure(cls_now);
        res_st_o    <= fx_selftest(cls_now);
        res_tsc_o   <= fx_tsc(cls_now);
      end
    end
  end

  for (genvar c = 0; c < FX_NUM; c++) begin : g_cls_cnt
    assign cls_inc[c] = win_end_i && (cls_now == fx_class_e'(c));
    fec_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .inc_i(cls_inc[c]),
      .cnt_o(cls_cnt[c])
    );
  end

  fec_sat_counter #(.W(CNT_W)) u_fa_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .inc_i(ev_false_alarm),
    .cnt_o(fa_cnt_o)
  );

  assign cnt_hidden_o  = cls_cnt[FX_HIDDEN];
  assign cnt_caught_o  = cls_cnt[FX_CAUGHT];
  assign cnt_missed_o  = cls_cnt[FX_MISSED];
  assign cnt_partial_o = cls_cnt[FX_PARTIAL];
endmodule

// File: rtl/fec_checker.sv
module fec_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             vld_i,
  input logic             win_end_i,
  input logic             res_vld_o,
  input logic [1:0]       res_class_o,
  input logic             res_fs_o,
  input logic             res_st_o,
  input logic             res_tsc_o,
  input logic [CNT_W-1:0] cnt_hidden_o,
  input logic [CNT_W-1:0] cnt_caught_o,
  input logic [CNT_W-1:0] cnt_missed_o,
  input logic [CNT_W-1:0] cnt_partial_o,
  input logic [CNT_W-1:0] fa_cnt_o,
  input logic             stk_wrong_q,
  input logic             stk_caught_q,
  input logic             stk_missed_q
);
  a_r7_result_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i |=> res_vld_o);

  a_r7_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end_i |=> !res_vld_o);

  a_r8_window_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i |=> (!stk_wrong_q && !stk_caught_q && !stk_missed_q));

  a_r1_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i && !win_end_i) |=>
      ($stable(stk_wrong_q) && $stable(stk_caught_q) && $stable(stk_missed_q)));

  a_r6_tsc_only_caught: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (res_tsc_o == (res_class_o == 2'd1)));

  a_r6_tsc_implies_fs_st: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_tsc_o) |-> (res_fs_o && res_st_o));

  a_r10_one_class_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ($countones({cnt_hidden_o != $past(cnt_hidden_o),
                              cnt_caught_o != $past(cnt_caught_o),
                              cnt_missed_o != $past(cnt_missed_o),
                              cnt_partial_o != $past(cnt_partial_o)}) <= 1));

  a_r10_hidden_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_hidden_o) && !clear_i) |=> (&cnt_hidden_o));

  a_r10_fa_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((&fa_cnt_o) && !clear_i) |=> (&fa_cnt_o));

  a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_hidden_o == '0 && cnt_caught_o == '0 && cnt_missed_o == '0 &&
                 cnt_partial_o == '0 && fa_cnt_o == '0));
endmodule

bind fault_effect_classifier fec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .vld_i(vld_i), .win_end_i(win_end_i),
  .res_vld_o(res_vld_o), .res_class_o(res_class_o), .res_fs_o(res_fs_o),
  .res_st_o(res_st_o), .res_tsc_o(res_tsc_o),
  .cnt_hidden_o(cnt_hidden_o), .cnt_caught_o(cnt_caught_o),
  .cnt_missed_o(cnt_missed_o), .cnt_partial_o(cnt_partial_o), .fa_cnt_o(fa_cnt_o),
  .stk_wrong_q(stk_wrong_q), .stk_caught_q(stk_caught_q), .stk_missed_q(stk_missed_q)
);

// File: tb/sim_fault_effect_classifier.sv
module sim_fault_effect_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clear_i = 1'b0, vld_i = 1'b0, ced_i = 1'b0, win_end_i = 1'b0;
  logic [DW-1:0] golden_i = '0, tested_i = '0;
  logic res_vld_o, res_fs_o, res_st_o, res_tsc_o;
  logic [1:0] res_class_o;
  logic [CW-1:0] cnt_hidden_o, cnt_caught_o, cnt_missed_o, cnt_partial_o, fa_cnt_o;

  int checks = 0, fails = 0, cycles = 0;
  int exp_cnt [4];
  int exp_fa;
  bit done = 0;

  fault_effect_classifier #(.DATA_W(DW), .CNT_W(CW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check_counters(input string req);
    check({req, " hidden cnt"},  cnt_hidden_o,  exp_cnt[0]);
    check({req, " caught cnt"},  cnt_caught_o,  exp_cnt[1]);
    check({req, " missed cnt"},  cnt_missed_o,  exp_cnt[2]);
    check({req, " partial cnt"}, cnt_partial_o, exp_cnt[3]);
    check({req, " false alarms"}, fa_cnt_o,     exp_fa);
  endtask

  // kinds: 0 invalid (junk data, flag up), 1 correct, 2 correct+flag,
  // 3 wrong+flag, 4 wrong no flag
  task automatic run_window(input int w, input bit clr_at_end, input bit after_end);
    bit wr = 0, ca = 0, mi = 0;
    int cls, fa_add = 0;
    for (int k = 0; k < 3; k++) begin
      int kind = (w / (k == 0 ? 1 : (k == 1 ? 5 : 25))) % 5;
      logic [DW-1:0] g = DW'((w * 7 + k * 3) & 15);
      // R7: result valid only right after an end strobe
      check("R7 res_vld", res_vld_o, (k == 0 && after_end) ? 1 : 0);
      vld_i = (kind != 0);
      golden_i = g;
      tested_i = (kind >= 3 || kind == 0) ? (g ^ DW'(1 << ((w + k) % DW))) : g;
      ced_i = (kind == 0 || kind == 2 || kind == 3);
      win_end_i = (k == 2);
      clear_i = clr_at_end && (k == 2);
      if (kind >= 3) wr = 1;
      if (kind == 3) ca = 1;
      if (kind == 4) mi = 1;
      if (kind == 2) fa_add++;
      @(negedge clk);
    end
    vld_i = 0; win_end_i = 0; clear_i = 0; ced_i = 0;
    cls = !wr ? 0 : (ca && mi) ? 3 : ca ? 1 : 2;
    if (clr_at_end) begin
      foreach (exp_cnt[i]) exp_cnt[i] = 0;
      exp_fa = 0;
    end else begin
      exp_cnt[cls] = sat(exp_cnt[cls] + 1);
      exp_fa = sat(exp_fa + fa_add);
    end
    check("R7 res_vld after end", res_vld_o, 1);
    case (cls)
      0: check("R2 class hidden",  res_class_o, 0);
      1: check("R3 class caught",  res_class_o, 1);
      2: check("R4 class missed",  res_class_o, 2);
      default: check("R5 class partial", res_class_o, 3);
    endcase
    check("R6 fs",  res_fs_o,  (cls == 0 || cls == 1) ? 1 : 0);
    check("R6 st",  res_st_o,  (cls == 1 || cls == 3) ? 1 : 0);
    check("R6 tsc", res_tsc_o, (cls == 1) ? 1 : 0);
    check_counters(clr_at_end ? "R11 clear on end" : "R10 R9 R8 R1");
  endtask

  initial begin
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    exp_fa = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 res_vld", res_vld_o, 0);
    check("R12 class", res_class_o, 0);
    check("R12 props", {res_fs_o, res_st_o, res_tsc_o}, 0);
    check_counters("R12");
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 125; w++) begin
      run_window(w, w == 90, w != 0 && w != 41);
      if (w == 40) begin
        // R11: standalone clear one cycle after a result
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        foreach (exp_cnt[i]) exp_cnt[i] = 0;
        exp_fa = 0;
        check("R11 res_vld drops", res_vld_o, 0);
        check_counters("R11 clear");
      end
    end
    summary();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end
endmodule